// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block brings one DDR2 SDRAM chip select from power-up to a usable state. After reset it idles and drives NOP on the command pins. A start request arms it, and it then waits until the PHY reports that its delay-locked loop has locked. Once lock is seen it holds NOP for a programmable number of cycles. It then issues a fixed list of eleven commands: two precharge-all commands, the three extended mode-register writes, two mode-register writes that first set and then clear DLL reset, two auto-refreshes, and the off-chip-driver calibration enter/exit pair.

Every wait between commands comes from a parameter: tMRD after a mode-register write, tRP after a precharge-all and tRFC after a refresh. An extra guard makes sure that at least T_DLL cycles separate the DLL-reset mode-register write from the calibration-default write. After the gap that follows the last command, the sequencer raises a done flag and a refresh-enable output for the main controller. Both stay high until reset.

Top module: `ddr2_init_seq`

## Requirements
- R1: No command other than NOP appears before both a start request and DLL lock have been seen, and every command output is registered.
- R2: The non-NOP commands appear in exactly this order, and no others appear: precharge-all, EMRS2, EMRS3, EMRS1, MRS (DLL reset), precharge-all, auto-refresh, auto-refresh, MRS (no DLL reset), EMRS1 (calibration default), EMRS1 (calibration exit).
- R3: The encodings on {csN, rasN, casN, weN} are NOP 0111, precharge-all 0010, auto-refresh 0001 and mode-register write 0000. A precharge-all drives addr bit 10 high and all other addr and ba bits low. NOP and auto-refresh drive ba and addr to zero.
- R4: Mode-register writes use ba 2 with addr 0 for EMRS2, ba 3 with addr 0 for EMRS3, and ba 1 with addr 0x400 for the first EMRS1. The MRS with DLL reset uses ba 0 with addr 0x542 and the MRS without reset uses ba 0 with addr 0x442. The calibration-default EMRS1 uses ba 1 with addr 0x780 and the calibration-exit EMRS1 uses ba 1 with addr 0x400.
- R5: The first precharge-all appears INIT_NOP_CYC+1 cycles after the cycle in which lock is first seen high while armed. If lock is already high when the start request is seen, it appears INIT_NOP_CYC+2 cycles after that start request.
- R6: Exactly T_MRD NOP cycles follow each mode-register write, T_RP follow each precharge-all and T_RFC follow each auto-refresh. The one exception is before the calibration-default EMRS1, which is governed by R7.
- R7: The calibration-default EMRS1 appears max(T_DLL, 2*(T_MRD+1)+(T_RP+1)+2*(T_RFC+1)) cycles after the DLL-reset MRS.
- R8: initDone and refreshEn are low throughout the sequence. Both rise together exactly T_MRD cycles after the last command appears.
- R9: initDone and refreshEn stay high until reset. A start request while busy or done produces no further commands.
- R10: NOP is driven on every cycle that carries no sequence command.
- R11: During and after reset the outputs show NOP with ba and addr at zero, and initDone and refreshEn are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request to begin initialization |
| dllLocked | input | 1 | PHY DLL lock indication |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address (selects the mode register) |
| addr | output | ADDR_W | Row address / mode-register payload |
| initDone | output | 1 | Sequence complete (sticky) |
| refreshEn | output | 1 | Permission for periodic refresh (sticky) |

## Verification
A wrong step index shows up at the pins on the very next issued command, as a wrong encoding, bank or payload. A miscounted wait shifts the following command by one or more cycles, so the spacing between consecutive commands exposes it. A fault in the DLL-time guard only shows at the calibration-default write, because that is the only command it gates. Faults in the final state show as initDone or refreshEn rising in the wrong cycle, rising apart from each other, or as commands that follow a second start request.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;
  localparam int STEP_W      = 4;
  localparam int LAST_STEP   = 10;
  localparam int DLLRST_STEP = 4;
  localparam int OCD_STEP    = 9;

  // {csN, rasN, casN, weN}
  localparam logic [3:0] ENC_NOP  = 4'b0111;
  localparam logic [3:0] ENC_PALL = 4'b0010;
  localparam logic [3:0] ENC_REF  = 4'b0001;
  localparam logic [3:0] ENC_MRS  = 4'b0000;

  typedef struct packed {
    logic              issue;
    logic              loadHold;
    logic              setDone;
    logic [STEP_W-1:0] step;
  } ctlStrobe_t;

  typedef struct packed {
    logic gapZero;
    logic dllOk;
  } dpStatus_t;
endpackage

// File: rtl/ddr2_init_ctl.sv
module ddr2_init_ctl
  import ddr2_init_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       dllLocked,
  input  dpStatus_t  status,
  output ctlStrobe_t strobe
);
  typedef enum logic [2:0] {S_IDLE, S_ARM, S_HOLD, S_ISSUE, S_GAP, S_DONE} state_t;

  state_t            stateQ, stateD;
  logic [STEP_W-1:0] stepQ, stepD;
  logic              ocdBlocked;

  assign ocdBlocked = (stepQ == STEP_W'(OCD_STEP)) && !status.dllOk;

  always_comb begin
    stateD          = stateQ;
    stepD           = stepQ;
    strobe.issue    = 1'b0;
    strobe.loadHold = 1'b0;
    strobe.setDone  = 1'b0;
    strobe.step     = stepQ;
    unique case (stateQ)
      S_IDLE: if (startReq) stateD = S_ARM;
      S_ARM: begin
        if (dllLocked) begin
          strobe.loadHold = 1'b1;
          stateD          = S_HOLD;
        end
      end
      S_HOLD: begin
        if (status.gapZero) begin
          stepD  = '0;
          stateD = S_ISSUE;
        end
      end
      S_ISSUE: begin
        if (!ocdBlocked) begin
          strobe.issue = 1'b1;
          stateD       = S_GAP;
        end
      end
      S_GAP: begin
        if (status.gapZero) begin
          if (stepQ == STEP_W'(LAST_STEP)) begin
            strobe.setDone = 1'b1;
            stateD         = S_DONE;
          end else begin
            stepD  = stepQ + STEP_W'(1);
            stateD = S_ISSUE;
          end
        end
      end
      S_DONE: stateD = S_DONE;
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      stepQ  <= '0;
    end else begin
      stateQ <= stateD;
      stepQ  <= stepD;
    end
  end

  // R6: a command is only issued once the preceding wait has run out
  p_issue_after_gap_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issue |-> status.gapZero);

  // R1: nothing is issued while idle or waiting for lock
  p_quiet_until_lock_r1: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_IDLE || stateQ == S_ARM) |=> !strobe.issue);

  // R9: once finished the controller never leaves the done state
  p_done_final_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_DONE) |=> (stateQ == S_DONE));
endmodule

// File: rtl/ddr2_init_dp.sv
module ddr2_init_dp
  import ddr2_init_pkg::*;
#(
  parameter int ADDR_W       = 14,
  parameter int BA_W         = 3,
  parameter int INIT_NOP_CYC = 25,
  parameter int T_MRD        = 2,
  parameter int T_RP         = 3,
  parameter int T_RFC        = 11,
  parameter int T_DLL        = 200
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  output dpStatus_t         status,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              done,
  output logic              refreshEn
);
  localparam int MAX_A   = (T_MRD > T_RP) ? T_MRD : T_RP;
  localparam int MAX_B   = (T_RFC > INIT_NOP_CYC) ? T_RFC : INIT_NOP_CYC;
  localparam int GAP_MAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(GAP_MAX + 1);
  localparam int DLL_W   = $clog2(T_DLL + 1);

  logic [3:0]        cmdEnc;
  logic [1:0]        cmdBa;
  logic [10:0]       cmdPay;
  logic [CNT_W-1:0]  gapLoad;
  logic [CNT_W-1:0]  gapCnt;
  logic [DLL_W-1:0]  dllCnt;
  logic              dllRun;
  logic [ADDR_W-1:0] addrNext;
  logic [3:0]        encQ;

  // step -> command, target register, payload, trailing wait
  always_comb begin
    cmdEnc  = ENC_MRS;
    cmdBa   = 2'd0;
    cmdPay  = 11'h000;
    gapLoad = CNT_W'(T_MRD - 1);
    unique case (strobe.step)
      4'd0, 4'd5: begin cmdEnc = ENC_PALL; cmdPay = 11'h400; gapLoad = CNT_W'(T_RP - 1); end
      4'd6, 4'd7: begin cmdEnc = ENC_REF;  gapLoad = CNT_W'(T_RFC - 1); end
      4'd1:  cmdBa = 2'd2;
      4'd2:  cmdBa = 2'd3;
      4'd3:  begin cmdBa = 2'd1; cmdPay = 11'h400; end
      4'd4:  cmdPay = 11'h542;
      4'd8:  cmdPay = 11'h442;
      4'd9:  begin cmdBa = 2'd1; cmdPay = 11'h780; end
      4'd10: begin cmdBa = 2'd1; cmdPay = 11'h400; end
      default: begin cmdEnc = ENC_NOP; end
    endcase
  end

  always_comb begin
    addrNext        = '0;
    addrNext[10:0]  = cmdPay;
  end

  // shared wait counter: initial hold and inter-command gaps
  always_ff @(posedge clk) begin
    if (!rstN)                gapCnt <= '0;
    else if (strobe.loadHold) gapCnt <= CNT_W'(INIT_NOP_CYC - 1);
    else if (strobe.issue)    gapCnt <= gapLoad;
    else if (gapCnt != '0)    gapCnt <= gapCnt - CNT_W'(1);
  end

  // cycles since the DLL-reset mode-register write, saturating
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dllRun <= 1'b0;
      dllCnt <= '0;
    end else if (strobe.issue && strobe.step == STEP_W'(DLLRST_STEP)) begin
      dllRun <= 1'b1;
      dllCnt <= DLL_W'(1);
    end else if (dllRun && dllCnt < DLL_W'(T_DLL)) begin
      dllCnt <= dllCnt + DLL_W'(1);
    end
  end

  assign status.gapZero = (gapCnt == '0);
  assign status.dllOk   = dllRun && (dllCnt >= DLL_W'(T_DLL));

  // registered pin drive
  always_ff @(posedge clk) begin
    if (!rstN) begin
      encQ <= ENC_NOP;
      ba   <= '0;
      addr <= '0;
    end else if (strobe.issue) begin
      encQ <= cmdEnc;
      ba   <= BA_W'(cmdBa);
      addr <= addrNext;
    end else begin
      encQ <= ENC_NOP;
      ba   <= '0;
      addr <= '0;
    end
  end

  assign {csN, rasN, casN, weN} = encQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done      <= 1'b0;
      refreshEn <= 1'b0;
    end else if (strobe.setDone) begin
      done      <= 1'b1;
      refreshEn <= 1'b1;
    end
  end

  // R6: every command is followed by at least one NOP
  p_nop_after_cmd_r6: assert property (@(posedge clk) disable iff (!rstN)
    (encQ != ENC_NOP) |=> (encQ == ENC_NOP));

  // R7: calibration-default write only after the DLL settle window
  p_ocd_after_dll_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issue && strobe.step == STEP_W'(OCD_STEP)) |-> status.dllOk);

  // R9: completion flags are sticky
  p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (done && refreshEn));

  // R3: a precharge-all always carries the all-banks bit
  p_pall_a10_r3: assert property (@(posedge clk) disable iff (!rstN)
    (encQ == ENC_PALL) |-> addr[10]);
endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
  import ddr2_init_pkg::*;
#(
  parameter int ADDR_W       = 14,
  parameter int BA_W         = 3,
  parameter int INIT_NOP_CYC = 25,
  parameter int T_MRD        = 2,
  parameter int T_RP         = 3,
  parameter int T_RFC        = 11,
  parameter int T_DLL        = 200
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              dllLocked,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              initDone,
  output logic              refreshEn
);
  ctlStrobe_t strobe;
  dpStatus_t  status;

  ddr2_init_ctl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .dllLocked (dllLocked),
    .status    (status),
    .strobe    (strobe)
  );

  ddr2_init_dp #(
    .ADDR_W       (ADDR_W),
    .BA_W         (BA_W),
    .INIT_NOP_CYC (INIT_NOP_CYC),
    .T_MRD        (T_MRD),
    .T_RP         (T_RP),
    .T_RFC        (T_RFC),
    .T_DLL        (T_DLL)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .status    (status),
    .csN       (csN),
    .rasN      (rasN),
    .casN      (casN),
    .weN       (weN),
    .ba        (ba),
    .addr      (addr),
    .done      (initDone),
    .refreshEn (refreshEn)
  );

  // R8: refresh is never enabled while a command is on the pins
  p_refresh_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    ({csN, rasN, casN, weN} != ENC_NOP) |-> !refreshEn);
endmodule

// File: tb/ddr2_init_seq_tb.sv
module ddr2_init_seq_tb;
  localparam int ADDR_W = 14;
  localparam int BA_W   = 3;
  localparam int P_INIT = 25;
  localparam int P_MRD  = 2;
  localparam int P_RP   = 3;
  localparam int P_RFC  = 11;
  localparam int P_DLL  = 200;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic dllLocked = 1'b0;
  logic csN, rasN, casN, weN, initDone, refreshEn;
  logic [BA_W-1:0]   ba;
  logic [ADDR_W-1:0] addr;

  int nChecks = 0;
  int nFails  = 0;
  int cyc     = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ddr2_init_seq #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .INIT_NOP_CYC(P_INIT),
    .T_MRD(P_MRD), .T_RP(P_RP), .T_RFC(P_RFC), .T_DLL(P_DLL)
  ) u_dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .dllLocked(dllLocked),
    .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .ba(ba), .addr(addr), .initDone(initDone), .refreshEn(refreshEn)
  );

  // monitor state
  logic monEn = 1'b0;
  int   nCmd;
  int   cmdCyc [16];
  logic [3:0] cmdEnc [16];
  int   cmdBa  [16];
  int   cmdAddr[16];
  int   startCyc, lockCyc, doneCyc;
  int   nopBad, refBad;

  always @(negedge clk) begin
    if (monEn) begin
      if (startCyc < 0 && startReq) startCyc = cyc;
      if (lockCyc < 0 && dllLocked) lockCyc = cyc;
      if (doneCyc < 0 && initDone) doneCyc = cyc;
      if (refreshEn !== initDone) refBad++;
      if ({csN, rasN, casN, weN} != 4'b0111) begin
        if (nCmd < 16) begin
          cmdCyc[nCmd]  = cyc;
          cmdEnc[nCmd]  = {csN, rasN, casN, weN};
          cmdBa[nCmd]   = int'(ba);
          cmdAddr[nCmd] = int'(addr);
        end
        nCmd++;
      end else if (ba != '0 || addr != '0) begin
        nopBad++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] expEnc(input int k);
    if (k == 0 || k == 5) return 4'b0010;
    if (k == 6 || k == 7) return 4'b0001;
    return 4'b0000;
  endfunction

  function automatic int expBa(input int k);
    case (k)
      1: return 2;
      2: return 3;
      3, 9, 10: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic int expAddr(input int k);
    case (k)
      0, 5, 3, 10: return 'h400;
      4: return 'h542;
      8: return 'h442;
      9: return 'h780;
      default: return 0;
    endcase
  endfunction

  function automatic int expGap(input int k);
    if (k == 0 || k == 5) return P_RP;
    if (k == 6 || k == 7) return P_RFC;
    return P_MRD;
  endfunction

  function automatic int expOcdSpacing();
    int nat;
    nat = 2 * (P_MRD + 1) + (P_RP + 1) + 2 * (P_RFC + 1);
    return (P_DLL > nat) ? P_DLL : nat;
  endfunction

  task automatic runSeq(input int startDly, input int lockDly);
    int waited;
    int expPall;
    nCmd = 0; startCyc = -1; lockCyc = -1; doneCyc = -1; nopBad = 0; refBad = 0;
    @(negedge clk); #1;
    rstN = 1'b0; startReq = 1'b0; dllLocked = 1'b0;
    repeat (3) @(negedge clk);
    // R11: reset state
    check({csN, rasN, casN, weN} == 4'b0111, "R11", "cmd in reset", {csN, rasN, casN, weN}, 4'b0111);
    check(initDone == 1'b0 && refreshEn == 1'b0, "R11", "flags in reset", {initDone, refreshEn}, 0);
    check(ba == '0 && addr == '0, "R11", "ba/addr in reset", int'(addr), 0);
    #1 rstN = 1'b1;
    monEn = 1'b1;
    fork
      begin
        repeat (startDly) @(negedge clk);
        #1 startReq = 1'b1;
        @(negedge clk); #1 startReq = 1'b0;
        // R9: a start request while busy is ignored
        repeat (40) @(negedge clk);
        #1 startReq = 1'b1;
        @(negedge clk); #1 startReq = 1'b0;
      end
      begin
        repeat (lockDly) @(negedge clk);
        #1 dllLocked = 1'b1;
      end
    join
    waited = 0;
    while (!initDone && waited < 3000) begin
      @(negedge clk);
      waited++;
    end
    check(initDone == 1'b1, "R8", "sequence finished", initDone, 1);
    // R9: start after done adds nothing
    @(negedge clk); #1 startReq = 1'b1;
    @(negedge clk); #1 startReq = 1'b0;
    repeat (60) @(negedge clk);
    monEn = 1'b0;
    check(initDone && refreshEn, "R9", "flags sticky", {initDone, refreshEn}, 3);
    // R2, R10: exactly eleven non-NOP cycles
    check(nCmd == 11, "R2", "command count", nCmd, 11);
    check(nopBad == 0, "R10", "NOP cycles with nonzero ba/addr", nopBad, 0);
    check(refBad == 0, "R8", "refreshEn differs from initDone", refBad, 0);
    if (nCmd == 11) begin
      for (int k = 0; k < 11; k++) begin
        check(cmdEnc[k] == expEnc(k), "R3", $sformatf("encoding of command %0d", k),
              cmdEnc[k], expEnc(k));
        check(cmdBa[k] == expBa(k) && cmdAddr[k] == expAddr(k), "R4",
              $sformatf("ba/addr of command %0d", k),
              (cmdBa[k] << 16) | cmdAddr[k], (expBa(k) << 16) | expAddr(k));
      end
      for (int k = 0; k < 10; k++) begin
        if (k == 8) begin
          check(cmdCyc[9] - cmdCyc[4] == expOcdSpacing(), "R7", "DLL-reset MRS to OCD default",
                cmdCyc[9] - cmdCyc[4], expOcdSpacing());
        end else begin
          check(cmdCyc[k + 1] - cmdCyc[k] == expGap(k) + 1, "R6",
                $sformatf("spacing after command %0d", k),
                cmdCyc[k + 1] - cmdCyc[k], expGap(k) + 1);
        end
      end
      expPall = (lockCyc > startCyc) ? lockCyc + P_INIT + 1 : startCyc + P_INIT + 2;
      check(cmdCyc[0] == expPall, "R5", "first precharge-all cycle", cmdCyc[0], expPall);
      check(cmdCyc[0] > lockCyc && cmdCyc[0] > startCyc, "R1", "no command before start and lock",
            cmdCyc[0], expPall);
      check(doneCyc == cmdCyc[10] + P_MRD, "R8", "done rise cycle", doneCyc, cmdCyc[10] + P_MRD);
    end
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    // directed: lock already high before start
    runSeq(20, 3);
    // directed: lock in the same cycle as start
    runSeq(10, 10);
    // directed: lock arrives long after start
    runSeq(2, 300);
    // random delays
    for (int r = 0; r < 6; r++) begin
      runSeq(1 + int'($urandom_range(0, 50)), 1 + int'($urandom_range(0, 80)));
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule